// File: doc/BRIEF.md
# Receive Frame Buffer with Quality Trailer

This block sits between a radio receive path and a host register port. It takes one received frame as a byte stream and stores it in a 144-byte buffer. The host sees the buffer as a window of byte registers. The first location holds the frame length. The frame bytes follow in arrival order, checksum included. The link-quality byte and then the signal-strength byte that came with the frame come right after the last frame byte. When a frame is fully stored, a receive flag is raised. The flag can drive an interrupt line.

The host protects the buffer while it reads it. It can set a receive-inhibit bit. It can also leave the receive flag set, because the flag also marks a frame that has not been read. In either case a frame that starts arriving is consumed and thrown away, and a saturating drop counter counts it. The length byte is the last location written for a frame. A frame that is still being written therefore never shows a new length.

The stream port uses valid/ready. A beat is taken on a clock edge where `in_valid` and `in_ready` are both high. The sender holds data, last, link-quality and signal-strength stable until the beat is taken. Link quality and signal strength are sampled on the beat marked last. The block drops `in_ready` only while it writes the trailer and the length.

Top module: `rx_frame_buf`

## Requirements
- R1: After reset the following hold. `in_ready` is 1, `irq` is 0, `drop_count` is 0 and `reg_rdata` is 0. The receive status register reads 0x00, the interrupt mask register reads 0x08 (receive interrupt masked), and the receive control register reads 0x00.
- R2: A stored frame of N bytes (N ≤ 141) places N at address 0x300. Frame byte k is at 0x301+k, in arrival order.
- R3: The link-quality byte sampled on the last beat is stored at 0x301+N. The signal-strength byte is stored at 0x302+N.
- R4: A frame longer than 141 bytes is taken in full. Only its first 141 bytes are stored, and the length byte reads 141. The link-quality byte is at 0x38E and the signal-strength byte at 0x38F.
- R5: After the last beat of a frame that is being stored is taken, `in_ready` is low for exactly three cycles and then high again. While idle, while storing frame bytes and while discarding a frame, `in_ready` stays high.
- R6: Storing a frame sets bit 3 of the receive status register at address 0x031. Reading that register returns the bit, then clears it. A frame stored in the same cycle as the read keeps it set.
- R7: `irq` is high exactly when the receive flag is set and bit 3 of the interrupt mask register at 0x032 is 0.
- R8: Bit 2 of the receive control register at 0x039 is the inhibit bit. A frame whose first beat is taken while this bit is 1 is discarded. The buffer does not change, the flag stays clear, and `drop_count` rises by one. Once the bit is cleared, frames are stored again.
- R9: A frame whose first beat is taken while the receive flag is set is discarded. The buffer does not change and `drop_count` rises by one.
- R10: `drop_count` saturates at its all-ones value.
- R11: While a frame is being stored, address 0x300 keeps the previous length and the flag stays clear. The new length appears only at the same time as the flag.
- R12: A register read returns its data on `reg_rdata` one cycle after the request. Unmapped addresses read 0. Host writes into the buffer window are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Frame beat valid |
| in_ready | output | 1 | Block can take a beat |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Beat is the final frame byte |
| in_lqi | input | 8 | Link quality, sampled with the last beat |
| in_rssi | input | 8 | Signal strength, sampled with the last beat |
| reg_en | input | 1 | Register access request |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 10 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, one cycle after the request |
| irq | output | 1 | Receive interrupt, active high |
| drop_count | output | 8 | Saturating count of discarded frames |

## Verification
The storage path is driven with a short frame, a one-byte frame, a frame paused halfway by a low `in_valid`, and a frame longer than the buffer. Together these separate correct byte offsets and trailer placement from off-by-one errors, show whether the length byte really comes last, and show whether clamping keeps the trailer in the last two locations. The drop path is driven once with the flag pending and once with the inhibit bit set. In both runs the bench confirms at the register port that the earlier frame is unchanged. A long run of one-byte frames under inhibit shows whether the drop counter saturates or wraps.

// File: rtl/rxfb_pkg.sv
package rxfb_pkg;
  typedef enum logic [2:0] {
    CAP_IDLE,
    CAP_DATA,
    CAP_DROP,
    CAP_LQI,
    CAP_RSSI,
    CAP_LEN
  } cap_state_t;

  localparam int ADR_STAT = 'h031;
  localparam int ADR_MASK = 'h032;
  localparam int ADR_RXCTL = 'h039;
  localparam int ADR_BUF = 'h300;
  localparam int FLAG_BIT = 3;
  localparam int INH_BIT = 2;
endpackage

// File: rtl/rxfb_capture.sv
module rxfb_capture
  import rxfb_pkg::*;
#(
  parameter int DEPTH = 144,
  parameter int IDX_W = 8,
  parameter int DROP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  input  logic [7:0]        in_lqi,
  input  logic [7:0]        in_rssi,
  input  logic              inhibit_i,
  input  logic              pending_i,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [7:0]        wr_data_o,
  output logic              commit_o,
  output logic [DROP_W-1:0] drop_count_o
);
  localparam int MAXF = DEPTH - 3;
  localparam logic [IDX_W-1:0] MAXF_C = IDX_W'(MAXF);

  cap_state_t state_q;
  logic [IDX_W-1:0] cnt_q;
  logic [7:0] lqi_q, rssi_q;
  logic [DROP_W-1:0] drop_q;
  logic take, refuse;

  assign in_ready = (state_q == CAP_IDLE) || (state_q == CAP_DATA) || (state_q == CAP_DROP);
  assign take = in_valid && in_ready;
  assign refuse = inhibit_i || pending_i;
  assign drop_count_o = drop_q;

  always_comb begin
    wr_en_o = 1'b0;
    wr_idx_o = '0;
    wr_data_o = '0;
    commit_o = 1'b0;
    case (state_q)
      CAP_IDLE: if (take && !refuse) begin
        wr_en_o = 1'b1;
        wr_idx_o = IDX_W'(1);
        wr_data_o = in_data;
      end
      CAP_DATA: if (take && (cnt_q < MAXF_C)) begin
        wr_en_o = 1'b1;
        wr_idx_o = cnt_q + 1'b1;
        wr_data_o = in_data;
      end
      CAP_LQI: begin
        wr_en_o = 1'b1;
        wr_idx_o = cnt_q + 1'b1;
        wr_data_o = lqi_q;
      end
      CAP_RSSI: begin
        wr_en_o = 1'b1;
        wr_idx_o = cnt_q + 2'd2;
        wr_data_o = rssi_q;
      end
      CAP_LEN: begin
        wr_en_o = 1'b1;
        wr_idx_o = '0;
        wr_data_o = 8'(cnt_q);
        commit_o = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= CAP_IDLE;
      cnt_q <= '0;
      lqi_q <= '0;
      rssi_q <= '0;
      drop_q <= '0;
    end else begin
      case (state_q)
        CAP_IDLE: if (take) begin
          if (refuse) begin
            if (drop_q != '1) drop_q <= drop_q + 1'b1;
            if (!in_last) state_q <= CAP_DROP;
          end else begin
            cnt_q <= IDX_W'(1);
            if (in_last) begin
              lqi_q <= in_lqi;
              rssi_q <= in_rssi;
              state_q <= CAP_LQI;
            end else begin
              state_q <= CAP_DATA;
            end
          end
        end
        CAP_DATA: if (take) begin
          if (cnt_q < MAXF_C) cnt_q <= cnt_q + 1'b1;
          if (in_last) begin
            lqi_q <= in_lqi;
            rssi_q <= in_rssi;
            state_q <= CAP_LQI;
          end
        end
        CAP_DROP: if (take && in_last) state_q <= CAP_IDLE;
        CAP_LQI: state_q <= CAP_RSSI;
        CAP_RSSI: state_q <= CAP_LEN;
        CAP_LEN: state_q <= CAP_IDLE;
        default: state_q <= CAP_IDLE;
      endcase
    end
  end

  // R4
  frame_len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= MAXF_C);

  // R8
  refuse_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CAP_IDLE && in_valid && refuse) |-> !wr_en_o);

  // R5
  ready_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> in_ready);

  // R10
  drop_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_q >= $past(drop_q));
endmodule

// File: rtl/rxfb_mem.sv
module rxfb_mem #(
  parameter int DEPTH = 144,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_data
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  logic [7:0] store_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store_q[wr_idx] <= wr_data;
  end

  assign rd_data = (rd_idx <= LAST_IDX) ? store_q[rd_idx] : 8'h00;

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_idx <= LAST_IDX);
endmodule

// File: rtl/rxfb_regs.sv
module rxfb_regs
  import rxfb_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int IDX_W = 8,
  parameter int DEPTH = 144
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              commit_i,
  output logic [IDX_W-1:0]  mem_rd_idx_o,
  input  logic [7:0]        mem_rd_data_i,
  output logic              inhibit_o,
  output logic              pending_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADR_STAT);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(ADR_MASK);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(ADR_RXCTL);
  localparam logic [ADDR_W-1:0] A_BUF_LO = ADDR_W'(ADR_BUF);
  localparam logic [ADDR_W-1:0] A_BUF_HI = ADDR_W'(ADR_BUF + DEPTH - 1);

  logic flag_q;
  logic [7:0] mask_q, ctl_q, rdata_q, rd_next;
  logic rd_req, wr_req, in_win;

  assign rd_req = reg_en && !reg_we;
  assign wr_req = reg_en && reg_we;
  assign in_win = (reg_addr >= A_BUF_LO) && (reg_addr <= A_BUF_HI);
  assign mem_rd_idx_o = IDX_W'(reg_addr - A_BUF_LO);
  assign inhibit_o = ctl_q[INH_BIT];
  assign pending_o = flag_q;
  assign irq_o = flag_q && !mask_q[FLAG_BIT];
  assign reg_rdata = rdata_q;

  always_comb begin
    rd_next = 8'h00;
    if (in_win) rd_next = mem_rd_data_i;
    else if (reg_addr == A_STAT) rd_next[FLAG_BIT] = flag_q;
    else if (reg_addr == A_MASK) rd_next = mask_q;
    else if (reg_addr == A_CTL) rd_next = ctl_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      mask_q <= 8'h08;
      ctl_q <= 8'h00;
      rdata_q <= 8'h00;
    end else begin
      if (rd_req) rdata_q <= rd_next;
      if (commit_i) flag_q <= 1'b1;
      else if (rd_req && reg_addr == A_STAT) flag_q <= 1'b0;
      if (wr_req && reg_addr == A_MASK) mask_q <= reg_wdata;
      if (wr_req && reg_addr == A_CTL) ctl_q <= reg_wdata;
    end
  end

  // R6
  flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(commit_i));

  // R6
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && reg_addr == A_STAT && !commit_i) |=> !flag_q);

  // R12
  win_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && in_win) |=> ($stable(mask_q) && $stable(ctl_q)));
endmodule

// File: rtl/rx_frame_buf.sv
module rx_frame_buf #(
  parameter int DEPTH = 144,
  parameter int ADDR_W = 10,
  parameter int DROP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  input  logic [7:0]        in_lqi,
  input  logic [7:0]        in_rssi,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq,
  output logic [DROP_W-1:0] drop_count
);
  localparam int IDX_W = $clog2(DEPTH);

  logic wr_en, commit, inhibit, pending;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [7:0] wr_data, rd_data;

  rxfb_capture #(.DEPTH(DEPTH), .IDX_W(IDX_W), .DROP_W(DROP_W)) cap_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_last(in_last), .in_lqi(in_lqi), .in_rssi(in_rssi),
    .inhibit_i(inhibit), .pending_i(pending),
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data),
    .commit_o(commit), .drop_count_o(drop_count)
  );

  rxfb_mem #(.DEPTH(DEPTH), .IDX_W(IDX_W)) mem_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data)
  );

  rxfb_regs #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DEPTH(DEPTH)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .commit_i(commit), .mem_rd_idx_o(rd_idx), .mem_rd_data_i(rd_data),
    .inhibit_o(inhibit), .pending_o(pending), .irq_o(irq)
  );
endmodule

// File: tb/rx_frame_buf_tb_top.sv
module rx_frame_buf_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, in_ready;
  logic [7:0] in_data = '0, in_lqi = '0, in_rssi = '0;
  logic reg_en = 1'b0, reg_we = 1'b0;
  logic [9:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic irq;
  logic [7:0] drop_count;

  int n_chk = 0, n_bad = 0, exp_drop = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  rx_frame_buf dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .in_lqi(in_lqi), .in_rssi(in_rssi),
    .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .drop_count(drop_count)
  );

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed * 29 + i * 7 + 5) & 255);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic read_reg(input int addr, output logic [7:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b0; reg_addr = 10'(addr);
    @(posedge clk);
    @(negedge clk);
    reg_en = 1'b0;
    d = reg_rdata;
  endtask

  task automatic write_reg(input int addr, input logic [7:0] v);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = 10'(addr); reg_wdata = v;
    @(posedge clk);
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic send_part(input int seed, input int from, input int upto,
                           input int total, input logic [7:0] lq, input logic [7:0] rs);
    for (int i = from; i < upto; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = pat(seed, i); in_last = (i == total - 1);
      in_lqi = lq; in_rssi = rs;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic expect_frame(input string req, input int n, input int seed,
                              input logic [7:0] lq, input logic [7:0] rs);
    logic [7:0] d;
    int st, bad0;
    st = (n > 141) ? 141 : n;
    bad0 = n_bad;
    read_reg('h300, d);
    chk({req, " length"}, d, st);
    for (int k = 0; k < st; k++) begin
      read_reg('h301 + k, d);
      if (d != pat(seed, k)) chk({req, " byte"}, d, pat(seed, k));
    end
    if (n_bad == bad0) n_chk++;
    read_reg('h301 + st, d);
    chk({req, " lqi"}, d, lq);
    read_reg('h302 + st, d);
    chk({req, " rssi"}, d, rs);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 in_ready", in_ready, 1);
    chk("R1 irq", irq, 0);
    chk("R1 drop", drop_count, 0);
    chk("R1 rdata", reg_rdata, 0);
    read_reg('h031, d); chk("R1 status", d, 8'h00);
    read_reg('h032, d); chk("R1 mask", d, 8'h08);
    read_reg('h039, d); chk("R1 ctl", d, 8'h00);
  endtask

  task automatic t_basic();
    logic [7:0] d;
    send_part(1, 0, 10, 10, 8'hA5, 8'h3C);
    chk("R5 ready low 1", in_ready, 0);
    @(negedge clk); chk("R5 ready low 2", in_ready, 0);
    @(negedge clk); chk("R5 ready low 3", in_ready, 0);
    @(negedge clk); chk("R5 ready back", in_ready, 1);
    chk("R7 masked irq", irq, 0);
    expect_frame("R2/R3 basic", 10, 1, 8'hA5, 8'h3C);
    read_reg('h031, d); chk("R6 flag set", d, 8'h08);
    read_reg('h031, d); chk("R6 flag cleared", d, 8'h00);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    write_reg('h032, 8'h00);
    chk("R7 irq idle", irq, 0);
    send_part(2, 0, 1, 1, 8'h11, 8'h22);
    settle();
    chk("R7 irq on", irq, 1);
    expect_frame("R2 one byte", 1, 2, 8'h11, 8'h22);
    write_reg('h032, 8'h08);
    chk("R7 irq remasked", irq, 0);
    write_reg('h032, 8'h00);
    chk("R7 irq unmasked", irq, 1);
    read_reg('h031, d);
    chk("R7 irq after clear", irq, 0);
  endtask

  task automatic t_pending();
    logic [7:0] d;
    send_part(3, 0, 4, 4, 8'h44, 8'h55);
    settle();
    send_part(9, 0, 6, 6, 8'h66, 8'h77);
    chk("R5 ready during drop", in_ready, 1);
    settle();
    exp_drop++;
    chk("R9 drop count", drop_count, exp_drop);
    expect_frame("R9 kept", 4, 3, 8'h44, 8'h55);
    read_reg('h031, d); chk("R9 flag", d, 8'h08);
  endtask

  task automatic t_inhibit();
    logic [7:0] d;
    write_reg('h039, 8'h04);
    read_reg('h039, d); chk("R12 ctl readback", d, 8'h04);
    send_part(12, 0, 7, 7, 8'h01, 8'h02);
    settle();
    exp_drop++;
    chk("R8 drop count", drop_count, exp_drop);
    chk("R8 irq", irq, 0);
    read_reg('h031, d); chk("R8 no flag", d, 8'h00);
    expect_frame("R8 kept", 4, 3, 8'h44, 8'h55);
    write_reg('h039, 8'h00);
    send_part(14, 0, 3, 3, 8'h0E, 8'hF0);
    settle();
    expect_frame("R8 resumed", 3, 14, 8'h0E, 8'hF0);
    read_reg('h031, d); chk("R8 resumed flag", d, 8'h08);
  endtask

  task automatic t_lenlast();
    logic [7:0] d;
    send_part(20, 0, 5, 8, 8'h9A, 8'hBC);
    read_reg('h300, d); chk("R11 old length", d, 3);
    read_reg('h031, d); chk("R11 no flag yet", d, 8'h00);
    send_part(20, 5, 8, 8, 8'h9A, 8'hBC);
    settle();
    expect_frame("R11 paused frame", 8, 20, 8'h9A, 8'hBC);
    read_reg('h031, d); chk("R11 flag", d, 8'h08);
  endtask

  task automatic t_clamp();
    logic [7:0] d;
    send_part(33, 0, 150, 150, 8'hC1, 8'hD2);
    settle();
    expect_frame("R4 clamp", 150, 33, 8'hC1, 8'hD2);
    read_reg('h38E, d); chk("R4 lqi slot", d, 8'hC1);
    read_reg('h38F, d); chk("R4 rssi slot", d, 8'hD2);
    read_reg('h031, d); chk("R4 flag", d, 8'h08);
  endtask

  task automatic t_hostwr();
    logic [7:0] d;
    write_reg('h305, 8'hAA);
    read_reg('h305, d); chk("R12 window write ignored", d, pat(33, 4));
    read_reg('h100, d); chk("R12 unmapped", d, 8'h00);
    read_reg('h390, d); chk("R12 past window", d, 8'h00);
  endtask

  task automatic t_sat();
    write_reg('h039, 8'h04);
    for (int f = 0; f < 300; f++) send_part(f, 0, 1, 1, 8'h00, 8'h00);
    settle();
    chk("R10 saturated", drop_count, 255);
    write_reg('h039, 8'h00);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_irq();
    t_pending();
    t_inhibit();
    t_lenlast();
    t_clamp();
    t_hostwr();
    t_sat();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule